// File: doc/BRIEF.md
# Long-Word Bus-Matching Width Converter

This block joins a 36-bit long-word path on the FIFO side to a narrow port whose active width is 36, 18 or 9 bits. Going toward the narrow port, each long word taken from the FIFO side is split into one, two or four pieces. The pieces are handed out over successive narrow reads. Going toward the FIFO, the pieces written at the narrow port are gathered until a full long word exists, and only then is that word offered to the FIFO side.

The width and the piece order (most significant piece first or least significant piece first) are captured while master reset is high. A separate partial reset empties both directions and leaves that configuration untouched. FIFO storage is outside this block. The FIFO side uses a valid/ready handshake in each direction. The narrow side has a read enable with a ready output, and a write enable with a ready output.

Top module: `bm_width_conv`

## Requirements
- R1: With `cfg_bus_match` low at master reset, the port is 36 bits wide: each long word is one piece, read out on `nar_rd_data` unchanged and written from `nar_wr_data` unchanged.
- R2: With `cfg_bus_match` high and `cfg_size` low, the port is 18 bits wide. Each long word is two pieces, the halves [17:0] and [35:18]. Read pieces appear on bits [17:0] with bits [35:18] zero. Write pieces are taken from bits [17:0], and bits [35:18] of `nar_wr_data` are ignored.
- R3: With `cfg_bus_match` high and `cfg_size` high, the port is 9 bits wide. Each long word is four bytes, at bits [8:0], [17:9], [26:18] and [35:27]. Read bytes appear on bits [8:0] with the rest zero. Write bytes are taken from bits [8:0], and the rest of `nar_wr_data` is ignored.
- R4: With `cfg_big_end` high at master reset, narrow reads deliver the most significant piece of each long word first and the least significant piece last.
- R5: With `cfg_big_end` low at master reset, narrow reads deliver the least significant piece first and the most significant piece last.
- R6: In the write direction, the first piece written after a word boundary lands in the most significant slot when big-endian is selected. It lands in the least significant slot when little-endian is selected.
- R7: Width and order are sampled only while `rst` is high. Changes on `cfg_bus_match`, `cfg_size` or `cfg_big_end` after reset have no effect.
- R8: `prst` empties the read side, so that `nar_rd_rdy` goes low and any pending long word is dropped. It also drops a pending push. Width and order are kept.
- R9: A long word is accepted from the FIFO side only when no pieces remain, or in the same cycle the last piece is read. `src_lw_ready` stays low and `nar_rd_rdy` stays high while pieces remain.
- R10: A long word is offered on `snk_lw_valid` only after all of its pieces have been written. It is held stable until `snk_lw_ready` is seen, and `nar_wr_rdy` is low while it waits.
- R11: `prst` discards a partly gathered long word, so the next piece written starts a new word.
- R12: After master reset, `nar_rd_rdy` and `snk_lw_valid` are low, while `src_lw_ready` and `nar_wr_rdy` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst | input | 1 | Master reset, synchronous, active high; captures configuration |
| prst | input | 1 | Partial reset, synchronous, active high; keeps configuration |
| cfg_bus_match | input | 1 | Narrow width select: low selects 36 bits, high selects 18 or 9 bits |
| cfg_size | input | 1 | When bus match is high: high selects 9 bits, low selects 18 bits |
| cfg_big_end | input | 1 | High: most significant piece moves first |
| src_lw_data | input | 36 | Long word from the FIFO, read direction |
| src_lw_valid | input | 1 | Long word on `src_lw_data` is valid |
| src_lw_ready | output | 1 | Converter takes the long word at this edge |
| nar_rd_en | input | 1 | Narrow read strobe |
| nar_rd_data | output | 36 | Current piece, right-aligned |
| nar_rd_rdy | output | 1 | A piece is available on `nar_rd_data` |
| nar_wr_en | input | 1 | Narrow write strobe |
| nar_wr_data | input | 36 | Piece to write, right-aligned |
| nar_wr_rdy | output | 1 | Converter accepts a narrow write at this edge |
| snk_lw_data | output | 36 | Gathered long word toward the FIFO |
| snk_lw_valid | output | 1 | `snk_lw_data` holds a complete long word |
| snk_lw_ready | input | 1 | FIFO takes the long word at this edge |

## Verification
The read data path has no register between the held long word and `nar_rd_data`. So the bench raises `nar_rd_en` just after a falling edge and checks the piece and `src_lw_ready` in that same half-cycle. A long word offered on the FIFO side shows up on `nar_rd_rdy` one rising edge later. A final narrow write, or a partial reset, shows its result one rising edge later, on `snk_lw_valid` or on the ready outputs. Every check is taken 1 ns after a falling edge, once the last rising edge has settled and before the next one.

// File: rtl/bm_conv_pkg.sv
package bm_conv_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int LW_W   = LANE_W * LANES;

    typedef enum logic [1:0] {
        PW_LONG = 2'd0,
        PW_WORD = 2'd1,
        PW_BYTE = 2'd2
    } port_width_e;

    typedef struct packed {
        port_width_e width;
        logic        big_end;
    } bm_cfg_t;

    function automatic port_width_e decode_width(input logic bus_match, input logic size);
        if (!bus_match)
            return PW_LONG;
        else if (size)
            return PW_BYTE;
        else
            return PW_WORD;
    endfunction

    // lanes carried by one narrow piece
    function automatic int lanes_per_piece(input port_width_e w, input int lanes);
        case (w)
            PW_WORD: return lanes / 2;
            PW_BYTE: return 1;
            default: return lanes;
        endcase
    endfunction

    // lane offset of piece k within the long word
    function automatic int slot_base(input int k, input int npieces, input int lpp,
                                     input logic big_end);
        int s;
        s = big_end ? (npieces - 1 - k) : k;
        return s * lpp;
    endfunction

endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
    import bm_conv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_match,
    input  logic    size,
    input  logic    big_end,
    output bm_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.width   <= decode_width(bus_match, size);
            cfg.big_end <= big_end;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(cfg)); // R7

endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
    import bm_conv_pkg::*;
#(
    parameter int LANE_W_P = bm_conv_pkg::LANE_W,
    parameter int LANES_P  = bm_conv_pkg::LANES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  bm_cfg_t                       cfg,
    input  logic [LANE_W_P*LANES_P-1:0]   lw_data,
    input  logic                          lw_valid,
    output logic                          lw_ready,
    input  logic                          rd_en,
    output logic [LANE_W_P*LANES_P-1:0]   rd_data,
    output logic                          rd_rdy
);

    localparam int W  = LANE_W_P * LANES_P;
    localparam int IW = (LANES_P > 1) ? $clog2(LANES_P) : 1;

    logic [W-1:0]  hold_q;
    logic          hold_v_q;
    logic [IW-1:0] idx_q;
    logic          last_piece;
    int            lpp;
    int            npc;
    int            base;

    always_comb begin
        lpp        = lanes_per_piece(cfg.width, LANES_P);
        npc        = LANES_P / lpp;
        last_piece = (int'(idx_q) == npc - 1);
        base       = slot_base(int'(idx_q), npc, lpp, cfg.big_end);
        rd_data    = '0;
        for (int j = 0; j < LANES_P; j++) begin
            if (j < lpp)
                rd_data[j*LANE_W_P +: LANE_W_P] = hold_q[(base + j)*LANE_W_P +: LANE_W_P];
        end
        rd_rdy   = hold_v_q;
        lw_ready = !hold_v_q || (rd_en && last_piece);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hold_q   <= '0;
            hold_v_q <= 1'b0;
            idx_q    <= '0;
        end else if (rd_en && hold_v_q && !last_piece) begin
            idx_q <= idx_q + 1'b1;
        end else if (lw_ready) begin
            hold_v_q <= lw_valid;
            idx_q    <= '0;
            if (lw_valid)
                hold_q <= lw_data;
        end
    end

    AST_READ_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst || flush)
        (rd_rdy && !rd_en) |=> (rd_rdy && $stable(rd_data))); // R9

    AST_FETCH_SHOWS: assert property (@(posedge clk) disable iff (rst || flush)
        (lw_valid && lw_ready) |=> rd_rdy); // R9

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) < npc); // R1

endmodule

// File: rtl/bm_pack.sv
module bm_pack
    import bm_conv_pkg::*;
#(
    parameter int LANE_W_P = bm_conv_pkg::LANE_W,
    parameter int LANES_P  = bm_conv_pkg::LANES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  bm_cfg_t                       cfg,
    input  logic                          wr_en,
    input  logic [LANE_W_P*LANES_P-1:0]   wr_data,
    output logic                          wr_rdy,
    output logic [LANE_W_P*LANES_P-1:0]   lw_data,
    output logic                          lw_valid,
    input  logic                          lw_ready
);

    localparam int W  = LANE_W_P * LANES_P;
    localparam int IW = (LANES_P > 1) ? $clog2(LANES_P) : 1;

    logic [W-1:0]  acc_q;
    logic [W-1:0]  merged;
    logic [IW-1:0] idx_q;
    logic          last_piece;
    logic          take;
    int            lpp;
    int            npc;
    int            base;

    always_comb begin
        lpp        = lanes_per_piece(cfg.width, LANES_P);
        npc        = LANES_P / lpp;
        last_piece = (int'(idx_q) == npc - 1);
        base       = slot_base(int'(idx_q), npc, lpp, cfg.big_end);
        merged     = acc_q;
        for (int j = 0; j < LANES_P; j++) begin
            if (j < lpp)
                merged[(base + j)*LANE_W_P +: LANE_W_P] = wr_data[j*LANE_W_P +: LANE_W_P];
        end
        wr_rdy = !lw_valid;
        take   = wr_en && wr_rdy;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc_q    <= '0;
            idx_q    <= '0;
            lw_data  <= '0;
            lw_valid <= 1'b0;
        end else begin
            if (lw_valid && lw_ready)
                lw_valid <= 1'b0;
            if (take) begin
                if (last_piece) begin
                    lw_data  <= merged;
                    lw_valid <= 1'b1;
                    acc_q    <= '0;
                    idx_q    <= '0;
                end else begin
                    acc_q <= merged;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst || flush)
        (lw_valid && !lw_ready) |=> (lw_valid && $stable(lw_data))); // R10

    AST_PUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst || flush)
        $rose(lw_valid) |-> $past(wr_en)); // R10

    AST_PACK_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) < npc); // R11

endmodule

// File: rtl/bm_width_conv.sv
module bm_width_conv
    import bm_conv_pkg::*;
#(
    parameter int LANE_W_P = bm_conv_pkg::LANE_W,
    parameter int LANES_P  = bm_conv_pkg::LANES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        prst,
    input  logic                        cfg_bus_match,
    input  logic                        cfg_size,
    input  logic                        cfg_big_end,
    input  logic [LANE_W_P*LANES_P-1:0] src_lw_data,
    input  logic                        src_lw_valid,
    output logic                        src_lw_ready,
    input  logic                        nar_rd_en,
    output logic [LANE_W_P*LANES_P-1:0] nar_rd_data,
    output logic                        nar_rd_rdy,
    input  logic                        nar_wr_en,
    input  logic [LANE_W_P*LANES_P-1:0] nar_wr_data,
    output logic                        nar_wr_rdy,
    output logic [LANE_W_P*LANES_P-1:0] snk_lw_data,
    output logic                        snk_lw_valid,
    input  logic                        snk_lw_ready
);

    bm_cfg_t cfg;

    bm_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .bus_match (cfg_bus_match),
        .size      (cfg_size),
        .big_end   (cfg_big_end),
        .cfg       (cfg)
    );

    bm_unpack #(.LANE_W_P(LANE_W_P), .LANES_P(LANES_P)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .flush    (prst),
        .cfg      (cfg),
        .lw_data  (src_lw_data),
        .lw_valid (src_lw_valid),
        .lw_ready (src_lw_ready),
        .rd_en    (nar_rd_en),
        .rd_data  (nar_rd_data),
        .rd_rdy   (nar_rd_rdy)
    );

    bm_pack #(.LANE_W_P(LANE_W_P), .LANES_P(LANES_P)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .flush    (prst),
        .cfg      (cfg),
        .wr_en    (nar_wr_en),
        .wr_data  (nar_wr_data),
        .wr_rdy   (nar_wr_rdy),
        .lw_data  (snk_lw_data),
        .lw_valid (snk_lw_valid),
        .lw_ready (snk_lw_ready)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        prst |=> (!nar_rd_rdy && !snk_lw_valid)); // R8

endmodule

// File: tb/bm_width_conv_test.sv
module bm_width_conv_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prst = 1'b0;
    logic        cfg_bus_match = 1'b0;
    logic        cfg_size = 1'b0;
    logic        cfg_big_end = 1'b0;
    logic [35:0] src_lw_data = '0;
    logic        src_lw_valid = 1'b0;
    logic        src_lw_ready;
    logic        nar_rd_en = 1'b0;
    logic [35:0] nar_rd_data;
    logic        nar_rd_rdy;
    logic        nar_wr_en = 1'b0;
    logic [35:0] nar_wr_data = '0;
    logic        nar_wr_rdy;
    logic [35:0] snk_lw_data;
    logic        snk_lw_valid;
    logic        snk_lw_ready = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bm_width_conv uut (
        .clk(clk), .rst(rst), .prst(prst),
        .cfg_bus_match(cfg_bus_match), .cfg_size(cfg_size), .cfg_big_end(cfg_big_end),
        .src_lw_data(src_lw_data), .src_lw_valid(src_lw_valid), .src_lw_ready(src_lw_ready),
        .nar_rd_en(nar_rd_en), .nar_rd_data(nar_rd_data), .nar_rd_rdy(nar_rd_rdy),
        .nar_wr_en(nar_wr_en), .nar_wr_data(nar_wr_data), .nar_wr_rdy(nar_wr_rdy),
        .snk_lw_data(snk_lw_data), .snk_lw_valid(snk_lw_valid), .snk_lw_ready(snk_lw_ready)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // mode: 0 = 36 bits, 1 = 18 bits, 2 = 9 bits
    function automatic int npieces(input int mode);
        return (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    endfunction

    function automatic logic [35:0] exp_piece(input logic [35:0] w, input int mode,
                                              input logic big, input int k);
        int b;
        if (mode == 0) return w;
        if (mode == 1) begin
            if ((k == 0) == big) return {18'h0, w[35:18]};
            else                 return {18'h0, w[17:0]};
        end
        b = big ? 3 - k : k;
        case (b)
            0:       return {27'h0, w[8:0]};
            1:       return {27'h0, w[17:9]};
            2:       return {27'h0, w[26:18]};
            default: return {27'h0, w[35:27]};
        endcase
    endfunction

    function automatic logic [35:0] junk_upper(input int mode);
        if (mode == 1) return {18'h3FFFF, 18'h0};
        if (mode == 2) return {27'h7FFFFFF, 9'h0};
        return '0;
    endfunction

    task automatic do_mreset(input logic bm, input logic sz, input logic big);
        @(negedge clk);
        cfg_bus_match = bm; cfg_size = sz; cfg_big_end = big;
        rst = 1'b1; nar_rd_en = 0; nar_wr_en = 0; src_lw_valid = 0; snk_lw_ready = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R12 nar_rd_rdy", {35'h0, nar_rd_rdy}, 36'h0);
        check("R12 snk_lw_valid", {35'h0, snk_lw_valid}, 36'h0);
        check("R12 src_lw_ready", {35'h0, src_lw_ready}, 36'h1);
        check("R12 nar_wr_rdy", {35'h0, nar_wr_rdy}, 36'h1);
    endtask

    task automatic rd_scenario(input logic [35:0] w, input int mode, input logic big,
                               input string req);
        int n;
        n = npieces(mode);
        @(negedge clk);
        src_lw_valid = 1'b1; src_lw_data = w;
        #1 check({req, " R9 ready when empty"}, {35'h0, src_lw_ready}, 36'h1);
        @(negedge clk);
        src_lw_valid = 1'b0;
        #1 check({req, " R9 rdy after fetch"}, {35'h0, nar_rd_rdy}, 36'h1);
        if (n > 1) check({req, " R9 no early fetch"}, {35'h0, src_lw_ready}, 36'h0);
        for (int k = 0; k < n; k++) begin
            nar_rd_en = 1'b1;
            #1;
            check({req, " piece"}, nar_rd_data, exp_piece(w, mode, big, k));
            check({req, " R9 fetch only on last"}, {35'h0, src_lw_ready},
                  {35'h0, (k == n - 1)});
            @(negedge clk);
        end
        nar_rd_en = 1'b0;
        #1 check({req, " R9 drained"}, {35'h0, nar_rd_rdy}, 36'h0);
    endtask

    task automatic wr_scenario(input logic [35:0] w, input int mode, input logic big,
                               input string req);
        int n;
        n = npieces(mode);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            nar_wr_en = 1'b1;
            nar_wr_data = exp_piece(w, mode, big, k) | junk_upper(mode);
            #1;
            check({req, " R10 wr_rdy"}, {35'h0, nar_wr_rdy}, 36'h1);
            check({req, " R10 no early push"}, {35'h0, snk_lw_valid}, 36'h0);
            @(negedge clk);
        end
        nar_wr_en = 1'b0;
        #1;
        check({req, " R10 push valid"}, {35'h0, snk_lw_valid}, 36'h1);
        check({req, " gathered word"}, snk_lw_data, w);
        check({req, " R10 wr blocked"}, {35'h0, nar_wr_rdy}, 36'h0);
        @(negedge clk);
        #1;
        check({req, " R10 push held"}, {35'h0, snk_lw_valid}, 36'h1);
        check({req, " R10 push stable"}, snk_lw_data, w);
        snk_lw_ready = 1'b1;
        @(negedge clk);
        snk_lw_ready = 1'b0;
        #1 check({req, " R10 push taken"}, {35'h0, snk_lw_valid}, 36'h0);
    endtask

    task automatic pulse_prst();
        @(negedge clk);
        prst = 1'b1;
        @(negedge clk);
        prst = 1'b0;
        #1;
        check("R8 rd emptied", {35'h0, nar_rd_rdy}, 36'h0);
        check("R8 push dropped", {35'h0, snk_lw_valid}, 36'h0);
    endtask

    task automatic test_long();
        do_mreset(1'b0, 1'b0, 1'b1);
        rd_scenario(36'h9_8765_4321, 0, 1'b1, "R1 rd");
        wr_scenario(36'h1_2345_6789, 0, 1'b1, "R1 wr");
    endtask

    task automatic test_word();
        do_mreset(1'b1, 1'b0, 1'b1);
        rd_scenario(36'hA_BCDE_F012, 1, 1'b1, "R2 R4 rd");
        wr_scenario(36'h3_1415_9265, 1, 1'b1, "R2 R6 big wr");
        do_mreset(1'b1, 1'b0, 1'b0);
        rd_scenario(36'h5_A5A5_0F0F, 1, 1'b0, "R2 R5 rd");
        wr_scenario(36'h2_7182_8182, 1, 1'b0, "R2 R6 little wr");
    endtask

    task automatic test_byte();
        do_mreset(1'b1, 1'b1, 1'b1);
        rd_scenario(36'hF_EDCB_A987, 2, 1'b1, "R3 R4 rd");
        wr_scenario(36'h8_0402_0100, 2, 1'b1, "R3 R6 big wr");
        do_mreset(1'b1, 1'b1, 1'b0);
        rd_scenario(36'h1_0203_0405, 2, 1'b0, "R3 R5 rd");
        wr_scenario(36'hC_33AA_5501, 2, 1'b0, "R3 R6 little wr");
    endtask

    task automatic test_cfg_frozen();
        do_mreset(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        cfg_bus_match = 1'b0; cfg_size = 1'b0; cfg_big_end = 1'b1;
        rd_scenario(36'h7_6655_4433, 2, 1'b0, "R7 rd");
        wr_scenario(36'h0_FEDC_BA98, 2, 1'b0, "R7 wr");
    endtask

    task automatic test_partial();
        do_mreset(1'b1, 1'b1, 1'b0);
        // half-gathered word must be dropped
        @(negedge clk);
        nar_wr_en = 1'b1; nar_wr_data = 36'h0_0000_01AA;
        @(negedge clk);
        nar_wr_data = 36'h0_0000_0155;
        @(negedge clk);
        nar_wr_en = 1'b0;
        pulse_prst();
        wr_scenario(36'h6_1234_5678, 2, 1'b0, "R11 wr after flush");
        // read side with pieces left
        @(negedge clk);
        src_lw_valid = 1'b1; src_lw_data = 36'hD_0000_0000;
        @(negedge clk);
        src_lw_valid = 1'b0; nar_rd_en = 1'b1;
        @(negedge clk);
        nar_rd_en = 1'b0;
        #1 check("R8 pieces remain before flush", {35'h0, nar_rd_rdy}, 36'h1);
        pulse_prst();
        check("R8 fetch open after flush", {35'h0, src_lw_ready}, 36'h1);
        rd_scenario(36'h4_0A0B_0C0D, 2, 1'b0, "R8 config kept rd");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        test_long();
        test_word();
        test_byte();
        test_cfg_frozen();
        test_partial();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule